// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter that advances once on every cycle in which a prescaled tick input is high and its run bit is set. When the count passes from 0xFF back to 0x00, a sticky overflow flag is raised. What that flag causes depends on the configuration. In interval mode it drives a level interrupt toward the processor. In watchdog mode it can instead produce a one-cycle reset request, drive a level non-maskable interrupt, or do nothing beyond setting the flag.

Software reaches the block through a plain register port with four word addresses. Address 0 is the control/status word. Address 1 is the live count, which can be read and written. Address 2 holds the reset-routing bits. Address 3 always reads zero. Reads are combinational and writes take effect at the next clock edge.

The overflow flag is protected against stale clears. A write of 0 clears it only after software has seen the flag as 1 on two separate reads, so a read that races the setting edge cannot arm the clear. There are only two other ways to drop the flag. One is the reset request the flag itself caused. The other is stopping the timer, which is selectable by parameter.

Top module: `wdt_timer`

## Requirements
- R1: After reset, address 0, address 1 and address 2 all read 0x00, and `irq_o`, `nmi_o` and `rst_req_o` are low.
- R2: The count (address 1) rises by one at each clock edge where `tick_i` is high and the run bit (address 0 bit 5) is 1. It holds when `tick_i` is low or when the run bit is 0.
- R3: A count step from 0xFF to 0x00 sets the overflow flag, which reads as address 0 bit 7, at that same edge.
- R4: A write to address 0 with bit 7 at 0 clears the flag only if at least two reads of address 0 returned the flag as 1 since it was last set. Otherwise the flag stays set. Writing 1 to bit 7 never sets it.
- R5: A read of address 0 in the cycle whose closing edge sets the flag returns bit 7 as 0, and that read does not count toward the two reads.
- R6: With address 0 bit 6 = 0 (interval mode), `irq_o` is high exactly while the flag is set.
- R7: In watchdog mode (address 0 bit 6 = 1) with reset-enable set (address 2 bit 6 = 1) and NMI-select clear (address 2 bit 5 = 0), an overflow raises `rst_req_o` for exactly one cycle, starting at the overflow edge. The following edge clears the flag.
- R8: In watchdog mode with NMI-select set (address 2 bit 5 = 1), `nmi_o` is high while the flag is set, and `rst_req_o` stays low.
- R9: In watchdog mode with address 2 bits 6 and 5 both 0, an overflow sets the flag but raises no request output.
- R10: A write to address 1 loads the count. A write to address 0 with bit 5 at 0 zeroes the count and also clears the flag.
- R11: If an overflow and any flag-clearing write meet at the same edge, the flag ends set, and two fresh qualifying reads are needed afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled count enable, one step per high cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (drives the flag-clear qualification) |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Interval interrupt request, level |
| nmi_o | output | 1 | Non-maskable interrupt request, level |
| rst_req_o | output | 1 | Internal reset request, one-cycle pulse |

## Verification
Two cases are hard to reach from the ports. The first is a read that lands in the very cycle the flag is being set. The second is a clearing write that lands on the overflow edge itself. The stimulus reaches both by loading the count with 0xFF through address 1, so the next tick is known to wrap. It then raises `tick_i` in the same cycle as the read strobe, or in the same cycle as the write strobe. A behavioural model predicts the flag, the qualifying-read tally, the count and every output on each clock. It exposes any disagreement in the race cycles as well as in the ordinary ones.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BUS_W = 8;
  localparam int AW    = 2;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_CNT  = 2'd1;
  localparam logic [AW-1:0] A_RSTC = 2'd2;

  // bit positions software relies on
  localparam int B_FLAG = 7;
  localparam int B_MODE = 6;
  localparam int B_RUN  = 5;
  localparam int B_REN  = 6;
  localparam int B_NMI  = 5;

  typedef struct packed {
    logic wdog;     // 1: watchdog, 0: interval
    logic run;      // count enable
    logic rst_en;   // reset routing allowed
    logic nmi_sel;  // route watchdog overflow to NMI
  } cfg_t;
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         zero_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         step;

  assign step   = run_i && tick_i && !load_i && !zero_i;
  assign wrap_o = step && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (zero_i) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_flag.sv
module wdt_flag #(
  parameter int READS_NEEDED   = 2,
  parameter bit STOP_CLEARS    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_ctrl_i,
  input  logic wr_zero_i,
  input  logic stop_i,
  input  logic sys_clr_i,
  output logic flag_o,
  output logic armed_o
);
  localparam int TW = $clog2(READS_NEEDED + 1);

  logic [TW-1:0] seen_q;
  logic          flag_q;
  logic          clr;

  assign armed_o = (seen_q >= TW'(READS_NEEDED));
  assign clr     = sys_clr_i || (wr_zero_i && armed_o) || (STOP_CLEARS && stop_i);
  assign flag_o  = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr)    flag_q <= 1'b0;
  end

  // tally of reads that returned the flag as set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   seen_q <= '0;
    else if (clr || !flag_q)                      seen_q <= '0;
    else if (rd_ctrl_i && !armed_o)               seen_q <= seen_q + 1'b1;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int W = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    wd_hi_i,   // write data bits 7..5
  input  logic          flag_i,
  input  logic [W-1:0]  cnt_i,
  output cfg_t          cfg_o,
  output logic          rd_ctrl_o,
  output logic          wr_zero_o,
  output logic          stop_o,
  output logic          load_o,
  output logic [W-1:0]  rdata_o
);
  cfg_t cfg_q;
  logic wr_ctrl, wr_rstc;

  assign wr_ctrl   = wr_i && (addr_i == A_CTRL);
  assign wr_rstc   = wr_i && (addr_i == A_RSTC);
  assign load_o    = wr_i && (addr_i == A_CNT);
  assign rd_ctrl_o = rd_i && (addr_i == A_CTRL);
  assign wr_zero_o = wr_ctrl && !wd_hi_i[B_FLAG-5];
  assign stop_o    = wr_ctrl && !wd_hi_i[B_RUN-5];
  assign cfg_o     = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg_q.wdog <= wd_hi_i[B_MODE-5];
        cfg_q.run  <= wd_hi_i[B_RUN-5];
      end
      if (wr_rstc) begin
        cfg_q.rst_en  <= wd_hi_i[B_REN-5];
        cfg_q.nmi_sel <= wd_hi_i[B_NMI-5];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[B_FLAG] = flag_i;
        rdata_o[B_MODE] = cfg_q.wdog;
        rdata_o[B_RUN]  = cfg_q.run;
      end
      A_CNT:  rdata_o = cnt_i;
      A_RSTC: begin
        rdata_o[B_REN] = cfg_q.rst_en;
        rdata_o[B_NMI] = cfg_q.nmi_sel;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int READS_NEEDED = 2,
  parameter bit STOP_CLEARS  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             rst_req_o
);
  cfg_t             cfg;
  logic             rd_ctrl, wr_zero, stop, load;
  logic [BUS_W-1:0] cnt;
  logic             wrap;
  logic             flag, armed;
  logic             rst_req_q;

  wdt_regs #(.W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .addr_i(bus_addr_i), .wd_hi_i(bus_wdata_i[7:5]), .flag_i(flag),
    .cnt_i(cnt), .cfg_o(cfg), .rd_ctrl_o(rd_ctrl), .wr_zero_o(wr_zero),
    .stop_o(stop), .load_o(load), .rdata_o(bus_rdata_o)
  );

  wdt_count #(.W(BUS_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(cfg.run),
    .load_i(load), .load_val_i(bus_wdata_i), .zero_i(stop),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  wdt_flag #(.READS_NEEDED(READS_NEEDED), .STOP_CLEARS(STOP_CLEARS)) u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(wrap), .rd_ctrl_i(rd_ctrl),
    .wr_zero_i(wr_zero), .stop_i(stop), .sys_clr_i(rst_req_q),
    .flag_o(flag), .armed_o(armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= wrap && cfg.wdog && cfg.rst_en && !cfg.nmi_sel;
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = flag && !cfg.wdog;
  assign nmi_o     = flag && cfg.wdog && cfg.nmi_sel;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk
  import wdt_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          bus_wr_i,
  input logic [AW-1:0] bus_addr_i,
  input logic          wrap,
  input logic          flag,
  input logic [7:0]    cnt,
  input logic          rst_req_o,
  input logic          nmi_o
);
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_i && !tick_i) |=> $stable(cnt));

  assert_wrap_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !rst_req_o && !(bus_wr_i && bus_addr_i == A_CTRL)) |=> flag);

  assert_rst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  assert_rst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && !wrap) |=> !flag);

  assert_nmi_no_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> !rst_req_o);
endmodule

bind wdt_timer wdt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
  .bus_addr_i(bus_addr_i), .wrap(wrap), .flag(flag), .cnt(cnt),
  .rst_req_o(rst_req_o), .nmi_o(nmi_o)
);

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'd0;
  logic [7:0] bus_rdata_o;
  logic       irq_o, nmi_o, rst_req_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wdt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
    .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  // behavioural reference state
  int m_cnt = 0, m_arm = 0;
  bit m_flag = 0, m_wdog = 0, m_run = 0, m_ren = 0, m_nmi = 0, m_rst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_arm = 0; m_flag = 0; m_wdog = 0; m_run = 0;
      m_ren = 0; m_nmi = 0; m_rst = 0;
    end else begin
      bit wr0, wr1, wr2, rd0, stop, wrap, clr;
      wr0  = bus_wr_i && bus_addr_i == 0;
      wr1  = bus_wr_i && bus_addr_i == 1;
      wr2  = bus_wr_i && bus_addr_i == 2;
      rd0  = bus_rd_i && bus_addr_i == 0;
      stop = wr0 && !bus_wdata_i[5];
      wrap = m_run && tick_i && !wr1 && !stop && m_cnt == 255;
      clr  = m_rst || (wr0 && !bus_wdata_i[7] && m_arm >= 2) || stop;
      if (clr || !m_flag) m_arm = 0;
      else if (rd0 && m_arm < 2) m_arm++;
      if (wrap) m_flag = 1; else if (clr) m_flag = 0;
      m_rst = wrap && m_wdog && m_ren && !m_nmi;
      if (stop) m_cnt = 0;
      else if (wr1) m_cnt = bus_wdata_i;
      else if (m_run && tick_i) m_cnt = (m_cnt + 1) % 256;
      if (wr0) begin m_wdog = bus_wdata_i[6]; m_run = bus_wdata_i[5]; end
      if (wr2) begin m_ren = bus_wdata_i[6]; m_nmi = bus_wdata_i[5]; end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int exp_rd;
      case (bus_addr_i)
        2'd0: exp_rd = {m_flag, m_wdog, m_run, 5'b0};
        2'd1: exp_rd = m_cnt;
        2'd2: exp_rd = {1'b0, m_ren, m_nmi, 5'b0};
        default: exp_rd = 0;
      endcase
      chk(bus_addr_i == 1 ? "R2 count" : "R4 register", bus_rdata_o, exp_rd);
      chk("R6 irq", irq_o, m_flag && !m_wdog);
      chk("R8 nmi", nmi_o, m_flag && m_wdog && m_nmi);
      chk("R7 rst_req", rst_req_o, m_rst);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit tk = 0);
    @(negedge clk);
    bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d; tick_i = tk;
    @(negedge clk);
    bus_wr_i = 0; tick_i = 0; bus_addr_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, input bit tk = 0);
    @(negedge clk);
    bus_rd_i = 1; bus_addr_i = a; tick_i = tk;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_rd_i = 0; tick_i = 0; bus_addr_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1;
    end
    @(negedge clk); tick_i = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, d); chk("R1 ctrl", d, 8'h00);
    rd(1, d); chk("R1 count", d, 8'h00);
    rd(2, d); chk("R1 rstc", d, 8'h00);
    chk("R1 outputs", {irq_o, nmi_o, rst_req_o}, 0);

    // R2 counting only on tick and run
    wr(1, 8'h10);
    ticks(3); rd(1, d); chk("R2 disabled hold", d, 8'h10);
    wr(0, 8'h20);
    ticks(5); repeat (2) @(negedge clk);
    rd(1, d); chk("R2 five ticks", d, 8'h15);

    // R3 / R6 overflow in interval mode
    wr(1, 8'hFE); ticks(2);
    rd(1, d); chk("R3 wrapped count", d, 8'h00);
    rd(0, d); chk("R3 flag set", d, 8'hA0);    // first qualifying read
    chk("R6 irq level", irq_o, 1);

    // R4 one read is not enough
    wr(0, 8'h20); chk("R4 one read no clear", irq_o, 1);
    rd(0, d); rd(0, d); wr(0, 8'h20);
    chk("R4 cleared after two reads", irq_o, 0);
    rd(0, d); chk("R4 ctrl after clear", d, 8'h20);

    // R5 read racing the set edge
    wr(1, 8'hFF);
    rd(0, d, 1); chk("R5 racing read", d, 8'h20);
    rd(0, d); chk("R5 later read", d, 8'hA0);
    wr(0, 8'h20); chk("R5 racing read not counted", irq_o, 1);
    rd(0, d); wr(0, 8'h20); chk("R5 clear after second read", irq_o, 0);

    // R10 load and stop
    wr(1, 8'hFF); ticks(1); chk("R10 flag before stop", irq_o, 1);
    wr(0, 8'h00);
    rd(0, d); chk("R10 stop clears flag", d, 8'h00);
    rd(1, d); chk("R10 stop zeroes count", d, 8'h00);
    ticks(3); rd(1, d); chk("R2 stopped hold", d, 8'h00);

    // R8 watchdog to NMI
    wr(2, 8'h60); wr(0, 8'h60); wr(1, 8'hFF); ticks(1);
    chk("R8 nmi high", nmi_o, 1); chk("R8 irq low", irq_o, 0);
    chk("R8 no reset", rst_req_o, 0);
    rd(0, d); rd(0, d); wr(0, 8'h60); chk("R8 nmi cleared", nmi_o, 0);

    // R7 watchdog to reset
    wr(2, 8'h40); wr(1, 8'hFF); ticks(1);
    #1 chk("R7 pulse", rst_req_o, 1);
    @(negedge clk); #1 chk("R7 pulse ends", rst_req_o, 0);
    rd(0, d); chk("R7 flag cleared by reset", d, 8'h60);

    // R9 watchdog with no routing
    wr(2, 8'h00); wr(1, 8'hFF); ticks(1);
    chk("R9 outputs quiet", {irq_o, nmi_o, rst_req_o}, 0);
    rd(0, d); chk("R9 flag set", d, 8'hE0);

    // R11 clearing write meets overflow
    rd(0, d); wr(1, 8'hFF);
    wr(0, 8'h60, 1);
    rd(0, d); chk("R11 set wins", d, 8'hE0);
    wr(0, 8'h60); rd(0, d); chk("R11 tally restarted", d, 8'hE0);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule